// File: doc/BRIEF.md
# RISC Operate-Class Arithmetic and Logic Unit

This block is the combinational execute stage for the operate class of a small 32-bit RISC machine. Each instruction in this class has a register form and a literal form. Opcode bit 4 selects the form. In the literal form, a 16-bit constant is sign-extended and used as the second operand in place of the second register value. The low four opcode bits choose the operation. The unit produces a 32-bit result, a signed-overflow indication for addition and subtraction, and a flag that marks opcodes the unit does not execute.

The surrounding pipeline reads the register file and presents both source values, the opcode and the literal field. It samples the outputs in the same cycle. When the flag is raised, the pipeline discards the result and hands the instruction to a software handler. Division is always handled this way.

Top module: `risc_alu_core`

## Requirements
- R1: When opcode bit 4 is 1, the second operand is the literal with its bit 15 copied into bits 31..16, and `src_b` has no effect. When opcode bit 4 is 0, the second operand is `src_b`, and `literal` has no effect.
- R2: Low code 0000 gives a+b, 0001 gives a-b, and 0010 gives a*b. Each result keeps only the low 32 bits.
- R3: Low code 0100 (equal), 0101 (less than) and 0110 (less or equal) compare both operands as signed values. The result is 32'h1 when the comparison is true and 32'h0 when it is false.
- R4: Low code 1000 gives bitwise AND, 1001 gives OR, 1010 gives XOR, and 1011 gives the complement of XOR.
- R5: Low code 1100 shifts a left and 1101 shifts a right. The shift distance is the value of bits 4..0 of the second operand, and vacated positions are filled with zeros. Higher operand bits have no effect.
- R6: Low code 1111 shifts a right by bits 4..0 of the second operand and fills vacated positions with bit 31 of a.
- R7: For low code 0000, `overflow` is 1 exactly when both operands have the same sign and the result sign differs from that sign.
- R8: For low code 0001, `overflow` is 1 exactly when the operands differ in sign and the result sign differs from the sign of a. For every other code, `overflow` is 0.
- R9: Some opcodes are unsupported: those with bit 5 equal to 0, and those whose low code is 0011, 0111 or 1110. For these, `unsupported` is 1, `result` is 0 and `overflow` is 0.
- R10: For every opcode with bit 5 equal to 1 and a low code not listed in R9, `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction opcode |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value (register form) |
| literal | input | 16 | Signed constant field (literal form) |
| result | output | 32 | Operation result |
| unsupported | output | 1 | Opcode not executed by this unit |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
Two functions settle in the same evaluation: the wrapped sum or difference, and the overflow flag computed from the same adder. The bench provokes both at once with the most negative and most positive values, in register form and with negative literals. It compares the wrapped word and the flag against a separate reference model. Literal sign extension and signed comparison also coincide: a literal of 16'hFFFF must compare equal to an all-ones register value. Both results are judged in the same sample.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 4'b0000,
        FN_SUB  = 4'b0001,
        FN_MUL  = 4'b0010,
        FN_DIV  = 4'b0011,
        FN_CEQ  = 4'b0100,
        FN_CLT  = 4'b0101,
        FN_CLE  = 4'b0110,
        FN_RSV7 = 4'b0111,
        FN_AND  = 4'b1000,
        FN_OR   = 4'b1001,
        FN_XOR  = 4'b1010,
        FN_XNOR = 4'b1011,
        FN_SHL  = 4'b1100,
        FN_SHR  = 4'b1101,
        FN_RSVE = 4'b1110,
        FN_SRA  = 4'b1111
    } alu_fn_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_CMP,
        GRP_LOGIC,
        GRP_SHIFT
    } alu_grp_e;

    typedef struct packed {
        logic     valid;
        logic     use_lit;
        alu_grp_e grp;
        alu_fn_e  fn;
    } alu_dec_t;

    function automatic alu_grp_e group_of(alu_fn_e fn);
        case (fn)
            FN_ADD, FN_SUB, FN_MUL, FN_DIV:    return GRP_ARITH;
            FN_CEQ, FN_CLT, FN_CLE, FN_RSV7:   return GRP_CMP;
            FN_AND, FN_OR, FN_XOR, FN_XNOR:    return GRP_LOGIC;
            default:                           return GRP_SHIFT;
        endcase
    endfunction

    function automatic alu_dec_t decode_op(logic [OPC_W-1:0] opc);
        alu_dec_t d;
        d.fn      = alu_fn_e'(opc[FN_W-1:0]);
        d.use_lit = opc[4];
        d.grp     = group_of(d.fn);
        d.valid   = opc[5] && !(d.fn inside {FN_DIV, FN_RSV7, FN_RSVE});
        return d;
    endfunction

endpackage

// File: rtl/risc_alu_decode.sv
module risc_alu_decode
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 16
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src_b,
    input  logic [LIT_W-1:0]  literal,
    output alu_dec_t          dec,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - LIT_W;

    logic [DATA_W-1:0] lit_wide;

    assign dec      = decode_op(opcode);
    assign lit_wide = {{EXT_W{literal[LIT_W-1]}}, literal};
    assign opnd_b   = dec.use_lit ? lit_wide : src_b;
endmodule

// File: rtl/risc_alu_arith.sv
module risc_alu_arith
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] arith_res,
    output logic [DATA_W-1:0] cmp_res,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic              sub_mode;
    logic [DATA_W-1:0] b_adj;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] prod;
    logic              v_raw;
    logic              is_lt;
    logic              is_eq;

    // one adder serves add, subtract and all three comparisons
    assign sub_mode = fn inside {FN_SUB, FN_CEQ, FN_CLT, FN_CLE};
    assign b_adj    = sub_mode ? ~b : b;
    assign sum      = a + b_adj + {{(DATA_W-1){1'b0}}, sub_mode};
    assign v_raw    = (a[MSB] == b_adj[MSB]) && (sum[MSB] != a[MSB]);
    assign prod     = a * b;

    assign is_lt = sum[MSB] ^ v_raw;
    assign is_eq = (a == b);

    always_comb begin
        case (fn)
            FN_ADD, FN_SUB: arith_res = sum;
            FN_MUL:         arith_res = prod;
            default:        arith_res = '0;
        endcase
    end

    always_comb begin
        cmp_res = '0;
        case (fn)
            FN_CEQ:  cmp_res[0] = is_eq;
            FN_CLT:  cmp_res[0] = is_lt;
            FN_CLE:  cmp_res[0] = is_lt | is_eq;
            default: cmp_res[0] = 1'b0;
        endcase
    end

    assign ovf = v_raw && (fn inside {FN_ADD, FN_SUB});
endmodule

// File: rtl/risc_alu_logic.sv
module risc_alu_logic
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] logic_res
);
    always_comb begin
        case (fn)
            FN_AND:  logic_res = a & b;
            FN_OR:   logic_res = a | b;
            FN_XOR:  logic_res = a ^ b;
            FN_XNOR: logic_res = ~(a ^ b);
            default: logic_res = '0;
        endcase
    end
endmodule

// File: rtl/risc_alu_shift.sv
module risc_alu_shift
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] shift_res
);
    logic              go_left;
    logic              fill;
    logic [DATA_W-1:0] a_rev;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stage [0:SH_W];

    assign go_left = (fn == FN_SHL);
    assign fill    = (fn == FN_SRA) & a[DATA_W-1];

    // left shift reuses the right shifter on a bit-reversed word
    for (genvar k = 0; k < DATA_W; k++) begin : g_rev
        assign a_rev[k]   = a[DATA_W-1-k];
        assign out_rev[k] = stage[SH_W][DATA_W-1-k];
    end

    assign stage[0] = go_left ? a_rev : a;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i]
            ? {{STEP{fill}}, stage[i][DATA_W-1:STEP]}
            : stage[i];
    end

    assign shift_res = go_left ? out_rev : stage[SH_W];
endmodule

// File: rtl/risc_alu_core.sv
module risc_alu_core
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 16
) (
    input  logic [5:0]        opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [LIT_W-1:0]  literal,
    output logic [DATA_W-1:0] result,
    output logic              unsupported,
    output logic              overflow
);
    localparam int SH_W = $clog2(DATA_W);

    alu_dec_t          dec;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] cmp_res;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] shift_res;
    logic              arith_ovf;
    logic [DATA_W-1:0] sel_res;

    risc_alu_decode #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_dec (
        .opcode (opcode),
        .src_b  (src_b),
        .literal(literal),
        .dec    (dec),
        .opnd_b (opnd_b)
    );

    risc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .fn       (dec.fn),
        .a        (src_a),
        .b        (opnd_b),
        .arith_res(arith_res),
        .cmp_res  (cmp_res),
        .ovf      (arith_ovf)
    );

    risc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .fn       (dec.fn),
        .a        (src_a),
        .b        (opnd_b),
        .logic_res(logic_res)
    );

    risc_alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .fn       (dec.fn),
        .a        (src_a),
        .amt      (opnd_b[SH_W-1:0]),
        .shift_res(shift_res)
    );

    always_comb begin
        case (dec.grp)
            GRP_ARITH: sel_res = arith_res;
            GRP_CMP:   sel_res = cmp_res;
            GRP_LOGIC: sel_res = logic_res;
            default:   sel_res = shift_res;
        endcase
    end

    assign result      = dec.valid ? sel_res : '0;
    assign unsupported = ~dec.valid;
    assign overflow    = dec.valid & arith_ovf;
endmodule

// File: rtl/risc_alu_core_chk.sv
module risc_alu_core_chk #(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 16
) (
    input logic [5:0]        opcode,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [LIT_W-1:0]  literal,
    input logic [DATA_W-1:0] result,
    input logic              unsupported,
    input logic              overflow
);
    always_comb begin
        // R9
        if (unsupported) begin
            unsupp_zero_chk: assert (result == '0 && !overflow)
                else $error("unsupported opcode left a result or overflow");
        end
        // R9
        if (!opcode[5]) begin
            class_flag_chk: assert (unsupported)
                else $error("opcode outside class not flagged");
        end
        // R3
        if (!unsupported && opcode[3:2] == 2'b01) begin
            cmp_bool_chk: assert (result[DATA_W-1:1] == '0)
                else $error("comparison result is not a 0/1 word");
        end
        // R8
        if (overflow) begin
            ovf_scope_chk: assert (opcode[3:1] == 3'b000)
                else $error("overflow raised outside add/subtract");
        end
        // R7
        if (overflow && opcode[3:0] == 4'b0000) begin
            add_ovf_sign_chk: assert (result[DATA_W-1] != src_a[DATA_W-1])
                else $error("add overflow without sign change");
        end
        // R5
        if (opcode == 6'b101100 && src_b[4:0] != 5'd0) begin
            shl_low_zero_chk: assert (result[0] == 1'b0)
                else $error("left shift did not clear bit 0");
        end
        // R1
        if (opcode == 6'b110000 && src_a == '0) begin
            lit_sext_chk: assert (result[DATA_W-1:LIT_W] == {(DATA_W-LIT_W){literal[LIT_W-1]}})
                else $error("literal not sign-extended");
        end
    end
endmodule

bind risc_alu_core risc_alu_core_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
    .opcode     (opcode),
    .src_a      (src_a),
    .src_b      (src_b),
    .literal    (literal),
    .result     (result),
    .unsupported(unsupported),
    .overflow   (overflow)
);

// File: tb/risc_alu_core_test.sv
module risc_alu_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode  = '0;
    logic [31:0] src_a   = '0;
    logic [31:0] src_b   = '0;
    logic [15:0] literal = '0;
    logic [31:0] result;
    logic        unsupported;
    logic        overflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    risc_alu_core uut (
        .opcode     (opcode),
        .src_a      (src_a),
        .src_b      (src_b),
        .literal    (literal),
        .result     (result),
        .unsupported(unsupported),
        .overflow   (overflow)
    );

    // expected {unsupported, overflow, result}
    function automatic logic [33:0] ref_model(logic [5:0] opc, logic [31:0] a,
                                              logic [31:0] b, logic [15:0] lit);
        logic [31:0] bop;
        logic [31:0] r;
        logic        ov;
        logic        us;
        bop = opc[4] ? {{16{lit[15]}}, lit} : b;
        r = '0; ov = 1'b0; us = 1'b0;
        if (!opc[5]) us = 1'b1;
        else begin
            case (opc[3:0])
                4'b0000: begin r = a + bop; ov = (a[31] == bop[31]) && (r[31] != a[31]); end
                4'b0001: begin r = a - bop; ov = (a[31] != bop[31]) && (r[31] != a[31]); end
                4'b0010: r = a * bop;
                4'b0100: r = {31'b0, a == bop};
                4'b0101: r = {31'b0, $signed(a) <  $signed(bop)};
                4'b0110: r = {31'b0, $signed(a) <= $signed(bop)};
                4'b1000: r = a & bop;
                4'b1001: r = a | bop;
                4'b1010: r = a ^ bop;
                4'b1011: r = ~(a ^ bop);
                4'b1100: r = a << bop[4:0];
                4'b1101: r = a >> bop[4:0];
                4'b1111: r = $unsigned($signed(a) >>> bop[4:0]);
                default: us = 1'b1;
            endcase
        end
        return {us, ov, r};
    endfunction

    function automatic string req_of(logic [5:0] opc);
        if (!opc[5]) return "R9";
        case (opc[3:0])
            4'b0000, 4'b0001, 4'b0010:  return "R2";
            4'b0100, 4'b0101, 4'b0110:  return "R3";
            4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R4";
            4'b1100, 4'b1101:           return "R5";
            4'b1111:                    return "R6";
            default:                    return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [5:0] opc, logic [31:0] a, logic [31:0] b,
                         logic [15:0] lit, string req);
        logic [33:0] e;
        @(negedge clk);
        opcode = opc; src_a = a; src_b = b; literal = lit;
        #1;
        e = ref_model(opc, a, b, lit);
        check(req, "result", result, e[31:0]);
        check(e[33] ? "R9" : "R10", "unsupported", {31'b0, unsupported}, {31'b0, e[33]});
        check(opc[3:0] == 4'b0000 ? "R7" : "R8", "overflow", {31'b0, overflow}, {31'b0, e[32]});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs are an out-of-class opcode (R9)
        @(negedge clk);
        #1;
        check("R9", "reset result", result, 32'h0);
        check("R9", "reset unsupported", {31'b0, unsupported}, 32'h1);
        rst = 1'b0;

        // R1: negative literal widened, src_b ignored
        apply(6'b110000, 32'h0, 32'h1234_5678, 16'h8000, "R1");
        apply(6'b110000, 32'h0, 32'hFFFF_FFFF, 16'h7FFF, "R1");
        // R1: register form ignores literal
        apply(6'b100000, 32'd5, 32'd7, 16'hFFFF, "R1");
        // R2 / R7 / R8 corners with the most negative and most positive values
        apply(6'b100000, 32'h7FFF_FFFF, 32'h1, 16'h0, "R7");
        apply(6'b100000, 32'h8000_0000, 32'h8000_0000, 16'h0, "R7");
        apply(6'b110000, 32'h8000_0000, 32'h0, 16'hFFFF, "R7");
        apply(6'b100001, 32'h8000_0000, 32'h1, 16'h0, "R8");
        apply(6'b100001, 32'h0, 32'h8000_0000, 16'h0, "R8");
        apply(6'b110001, 32'h7FFF_FFFF, 32'h0, 16'hFFFF, "R8");
        apply(6'b100010, 32'h0001_0000, 32'h0001_0000, 16'h0, "R2");
        apply(6'b110010, 32'd3, 32'h0, 16'hFFFE, "R2");
        // R3 signed comparisons
        apply(6'b100101, 32'h8000_0000, 32'h1, 16'h0, "R3");
        apply(6'b100101, 32'h1, 32'h8000_0000, 16'h0, "R3");
        apply(6'b100110, 32'h8000_0000, 32'h8000_0000, 16'h0, "R3");
        apply(6'b110100, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "R3");
        // R4 logic
        apply(6'b101011, 32'hF0F0_1234, 32'h0FF0_4321, 16'h0, "R4");
        apply(6'b111010, 32'hA5A5_A5A5, 32'h0, 16'hFFFF, "R4");
        // R5 shifts: amount 0, 31, and upper bits ignored
        apply(6'b101100, 32'h3, 32'd31, 16'h0, "R5");
        apply(6'b101101, 32'h8000_0001, 32'h20, 16'h0, "R5");
        apply(6'b111101, 32'h8000_0000, 32'h0, 16'hFFFF, "R5");
        // R6 arithmetic right
        apply(6'b111111, 32'h8000_0000, 32'h0, 16'd31, "R6");
        apply(6'b101111, 32'h4000_0000, 32'd0, 16'h0, "R6");
        // R9 unsupported codes
        apply(6'b100011, 32'd10, 32'd2, 16'h0, "R9");
        apply(6'b110111, 32'd10, 32'd2, 16'h0, "R9");
        apply(6'b101110, 32'd10, 32'd2, 16'h0, "R9");
        apply(6'b011011, 32'd10, 32'd2, 16'h0, "R9");

        // constrained random: mostly in-class opcodes, some corner operands
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [5:0]  opc;
            logic [31:0] a;
            logic [31:0] b;
            int          pick;
            opc  = ($urandom % 8 == 0) ? 6'($urandom) : {1'b1, 5'($urandom)};
            pick = $urandom % 6;
            a    = (pick == 0) ? 32'h8000_0000 : (pick == 1) ? 32'h7FFF_FFFF : $urandom;
            b    = (pick == 2) ? 32'h8000_0000 : (pick == 3) ? 32'(($urandom % 2) * 31) : $urandom;
            apply(opc, a, b, 16'($urandom), req_of(opc));
        end

        finish_run();
    end
endmodule